// File: doc/BRIEF.md
# Relocation and Limit Protection Unit

This block sits between a processor's address generator and memory. It translates and guards every address that a user-mode process issues. It holds two registers: a relocation base and a limit. For a user-mode request, the block first compares the logical address with the limit. If the address is in range, the block adds the base to it and issues the resulting physical address. If it is out of range, the block suppresses the access and raises a trap that reports an addressing error. Supervisor-mode requests pass straight through, with no translation and no check.

Only a privileged write may load the base and limit registers, as the operating system does during a context switch. A write attempted from user mode changes nothing and is flagged on a dedicated output. Requests enter through a valid/ready handshake. Each result, a physical address plus a trap flag, comes out of a register one cycle after its request is accepted. The result then stays on the outputs until the consumer takes it.

Top module: `reloc_guard`

## Requirements
- R1: After reset, the base and limit are both zero and no response is pending. So `rsp_valid_o=0`, `req_ready_o=1` and `cfg_deny_o=0`, and every user-mode request traps until a privileged write loads the registers.
- R2: A cycle with `cfg_we_i=1` and `cfg_priv_i=1` loads `cfg_base_i` and `cfg_limit_i`. The new values apply to requests accepted from the next cycle on. A request accepted in the same cycle as the write uses the old values.
- R3: A user-mode request (`req_priv_i=0`) with a logical address strictly below the limit returns `rsp_trap_o=0` and `rsp_addr_o = base + address`, taken modulo 2^AW. For example, base 14000 maps logical 0 to 14000 and logical 346 to 14346.
- R4: A user-mode request whose logical address is greater than or equal to the limit returns `rsp_trap_o=1` with `rsp_addr_o=0`, so no access is issued.
- R5: A write with `cfg_we_i=1` and `cfg_priv_i=0` leaves the base and limit unchanged, and `cfg_deny_o` is 1 in the following cycle.
- R6: `req_ready_o = !rsp_valid_o || rsp_ready_i`. A response is valid in the cycle after its request is accepted, and it holds stable until a cycle in which `rsp_ready_i=1`. Responses come out in request order.
- R7: A supervisor-mode request (`req_priv_i=1`) returns its address unchanged with `rsp_trap_o=0`, whatever the base and limit hold.
- R8: The range check is exact at its edges. An address of limit-1 is legal, and an address equal to the limit traps. For example, with base 300040 and limit 120900, logical 120899 maps to 420939 and logical 120900 traps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_priv_i | input | 1 | Write is privileged (1) or from user mode (0) |
| cfg_base_i | input | AW | New relocation base |
| cfg_limit_i | input | AW | New limit (size of the legal range) |
| cfg_deny_o | output | 1 | A user-mode write was refused in the previous cycle |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request can be accepted |
| req_priv_i | input | 1 | 1 = supervisor request, 0 = user request |
| req_addr_i | input | AW | Logical address |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ready_i | input | 1 | Consumer takes the response |
| rsp_addr_o | output | AW | Physical address (0 when trapped) |
| rsp_trap_o | output | 1 | Addressing error trap |

## Verification
The translation is tried with several base and limit pairs:
- A small base with a small limit separates adding the base from passing the address through.
- A base near the top of the address space separates modulo wrap from saturation.
- A zero limit shows that the check at reset works, apart from any translation.

Addresses at limit-1, at the limit and far above it separate a strict comparison from a non-strict one. Supervisor requests with addresses above the limit show that the bypass skips both the check and the add. A write issued together with a request, and a burst sent under an irregular consumer stall pattern, show which register values each request sees and that results are neither dropped nor reordered.

// File: rtl/reloc_guard_pkg.sv
package reloc_guard_pkg;
  typedef enum logic {
    MODE_USER = 1'b0,
    MODE_SUPV = 1'b1
  } mode_e;
endpackage

// File: rtl/reloc_regs.sv
module reloc_regs #(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          priv_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] limit_i,
  output logic [AW-1:0] base_o,
  output logic [AW-1:0] limit_o,
  output logic          deny_o
);
  logic load;
  assign load = we_i & priv_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_o  <= '0;
      limit_o <= '0;
      deny_o  <= 1'b0;
    end else begin
      if (load) begin
        base_o  <= base_i;
        limit_o <= limit_i;
      end
      deny_o <= we_i & ~priv_i;
    end
  end
endmodule

// File: rtl/reloc_xlate.sv
module reloc_xlate
  import reloc_guard_pkg::*;
#(
  parameter int AW = 32
) (
  input  mode_e         mode_i,
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] limit_i,
  output logic [AW-1:0] phys_o,
  output logic          trap_o
);
  logic in_range;
  // bounds check on the logical address, before relocation
  assign in_range = addr_i < limit_i;

  always_comb begin
    if (mode_i == MODE_SUPV) begin
      phys_o = addr_i;
      trap_o = 1'b0;
    end else if (in_range) begin
      phys_o = base_i + addr_i;
      trap_o = 1'b0;
    end else begin
      phys_o = '0;
      trap_o = 1'b1;
    end
  end
endmodule

// File: rtl/reloc_rsp_stage.sv
module reloc_rsp_stage #(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          take_i,
  input  logic [AW-1:0] phys_i,
  input  logic          trap_i,
  output logic          valid_o,
  output logic [AW-1:0] phys_o,
  output logic          trap_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      phys_o  <= '0;
      trap_o  <= 1'b0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      phys_o  <= phys_i;
      trap_o  <= trap_i;
    end else if (take_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/reloc_guard.sv
module reloc_guard
  import reloc_guard_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic          cfg_priv_i,
  input  logic [AW-1:0] cfg_base_i,
  input  logic [AW-1:0] cfg_limit_i,
  output logic          cfg_deny_o,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_priv_i,
  input  logic [AW-1:0] req_addr_i,
  output logic          rsp_valid_o,
  input  logic          rsp_ready_i,
  output logic [AW-1:0] rsp_addr_o,
  output logic          rsp_trap_o
);
  logic [AW-1:0] base_w, limit_w, phys_w;
  logic          trap_w, accept;

  assign req_ready_o = ~rsp_valid_o | rsp_ready_i;
  assign accept      = req_valid_i & req_ready_o;

  reloc_regs #(.AW(AW)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .priv_i  (cfg_priv_i),
    .base_i  (cfg_base_i),
    .limit_i (cfg_limit_i),
    .base_o  (base_w),
    .limit_o (limit_w),
    .deny_o  (cfg_deny_o)
  );

  reloc_xlate #(.AW(AW)) u_xlate (
    .mode_i  (mode_e'(req_priv_i)),
    .addr_i  (req_addr_i),
    .base_i  (base_w),
    .limit_i (limit_w),
    .phys_o  (phys_w),
    .trap_o  (trap_w)
  );

  reloc_rsp_stage #(.AW(AW)) u_rsp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept),
    .take_i  (rsp_ready_i),
    .phys_i  (phys_w),
    .trap_i  (trap_w),
    .valid_o (rsp_valid_o),
    .phys_o  (rsp_addr_o),
    .trap_o  (rsp_trap_o)
  );
endmodule

// File: rtl/reloc_guard_chk.sv
module reloc_guard_chk #(
  parameter int AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cfg_we_i,
  input logic          cfg_priv_i,
  input logic          cfg_deny_o,
  input logic          req_valid_i,
  input logic          req_ready_o,
  input logic          req_priv_i,
  input logic [AW-1:0] req_addr_i,
  input logic          rsp_valid_o,
  input logic          rsp_ready_i,
  input logic [AW-1:0] rsp_addr_o,
  input logic          rsp_trap_o,
  input logic [AW-1:0] limit_q
);
  logic acc;
  assign acc = req_valid_i & req_ready_o;

  AST_RSP_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> rsp_valid_o); // R6
  AST_RSP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ready_i) |=> (rsp_valid_o && $stable(rsp_addr_o) && $stable(rsp_trap_o))); // R6
  AST_TRAP_NO_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_trap_o) |-> (rsp_addr_o == '0)); // R4
  AST_USER_OUT_TRAPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !req_priv_i && (req_addr_i >= limit_q)) |=> rsp_trap_o); // R4
  AST_SUPV_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && req_priv_i) |=> (!rsp_trap_o && rsp_addr_o == $past(req_addr_i))); // R7
  AST_USER_CFG_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && !cfg_priv_i) |=> cfg_deny_o); // R5
  AST_PRIV_CFG_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cfg_we_i && !cfg_priv_i) |=> !cfg_deny_o); // R5
endmodule

bind reloc_guard reloc_guard_chk #(.AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_we_i    (cfg_we_i),
  .cfg_priv_i  (cfg_priv_i),
  .cfg_deny_o  (cfg_deny_o),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .req_priv_i  (req_priv_i),
  .req_addr_i  (req_addr_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_ready_i (rsp_ready_i),
  .rsp_addr_o  (rsp_addr_o),
  .rsp_trap_o  (rsp_trap_o),
  .limit_q     (limit_w)
);

// File: tb/reloc_guard_tb.sv
module reloc_guard_tb;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0, cfg_priv = 1'b0;
  logic [AW-1:0] cfg_base = '0, cfg_limit = '0;
  logic          cfg_deny;
  logic          req_valid = 1'b0, req_ready, req_priv = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          rsp_valid, rsp_ready, rsp_trap;
  logic [AW-1:0] rsp_addr;

  always #5 clk = ~clk;

  reloc_guard #(.AW(AW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_priv_i(cfg_priv), .cfg_base_i(cfg_base),
    .cfg_limit_i(cfg_limit), .cfg_deny_o(cfg_deny),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_priv_i(req_priv),
    .req_addr_i(req_addr), .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready),
    .rsp_addr_o(rsp_addr), .rsp_trap_o(rsp_trap)
  );

  typedef struct {
    logic [AW-1:0] addr;
    logic          trap;
    string         tag;
  } exp_t;

  exp_t          sb[$];
  int            total = 0, bad = 0;
  logic [AW-1:0] m_base = '0, m_lim = '0;
  logic          bp_en = 1'b0;
  int            bp_cnt = 0;
  bit            done = 1'b0;

  // consumer stall pattern
  always @(negedge clk) begin
    bp_cnt <= bp_cnt + 1;
    rsp_ready <= !bp_en || (bp_cnt % 3 != 0);
  end
  initial rsp_ready = 1'b1;

  task automatic check(input bit ok, input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    #2;
    if (rst_n && rsp_valid && rsp_ready) begin
      if (sb.size() == 0) begin
        check(1'b0, "R6 unexpected response", rsp_addr, '0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(rsp_addr == e.addr, {e.tag, " addr"}, rsp_addr, e.addr);
        check(rsp_trap == e.trap, {e.tag, " trap"}, AW'(rsp_trap), AW'(e.trap));
      end
    end
    if (rst_n && rsp_valid && !rsp_ready)
      check(req_ready == 1'b0, "R6 ready while stalled", AW'(req_ready), '0);
  end

  function automatic exp_t model(input logic priv, input logic [AW-1:0] a, input string tag);
    exp_t e;
    e.tag = tag;
    if (priv) begin e.addr = a; e.trap = 1'b0; end
    else if (a < m_lim) begin e.addr = m_base + a; e.trap = 1'b0; end
    else begin e.addr = '0; e.trap = 1'b1; end
    return e;
  endfunction

  // starts and ends at a negedge
  task automatic send(input logic priv, input logic [AW-1:0] a, input string tag);
    req_valid = 1'b1; req_priv = priv; req_addr = a;
    #1;
    while (!req_ready) begin
      @(negedge clk); #1;
    end
    sb.push_back(model(priv, a, tag));
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic cfg(input logic priv, input logic [AW-1:0] b, input logic [AW-1:0] l, input string tag);
    cfg_we = 1'b1; cfg_priv = priv; cfg_base = b; cfg_limit = l;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
    if (priv) begin m_base = b; m_lim = l; end
    #1;
    check(cfg_deny == !priv, {tag, " deny flag"}, AW'(cfg_deny), AW'(!priv));
  endtask

  task automatic drain();
    int n = 0;
    while ((sb.size() != 0 || rsp_valid) && n < 1000) begin
      @(negedge clk); n++;
    end
    @(negedge clk);
  endtask

  initial begin
    int wd = 0;
    while (!done) begin
      @(posedge clk);
      wd++;
      if (wd > 100000) begin
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=<100000", wd);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    check(rsp_valid == 1'b0, "R1 rsp_valid", AW'(rsp_valid), '0);
    check(req_ready == 1'b1, "R1 req_ready", AW'(req_ready), 1);
    check(cfg_deny == 1'b0, "R1 cfg_deny", AW'(cfg_deny), '0);
    rst_n = 1'b1;
    @(negedge clk);
    send(1'b0, 32'd0, "R1 user traps at reset");
    send(1'b1, 32'h1234, "R7 supv bypass");
    cfg(1'b1, 32'd14000, 32'd1000, "R2 priv load");
    send(1'b0, 32'd0, "R3 logical 0");
    send(1'b0, 32'd346, "R3 logical 346");
    send(1'b0, 32'd999, "R8 limit-1 legal");
    send(1'b0, 32'd1000, "R8 at limit traps");
    send(1'b0, 32'h8000_0000, "R4 far out traps");
    cfg(1'b0, 32'd5, 32'd5, "R5 user write");
    send(1'b0, 32'd346, "R5 regs unchanged");
    send(1'b0, 32'd5, "R5 limit unchanged");
    send(1'b1, 32'hFFFF_FFFF, "R7 supv above limit");
    cfg(1'b1, 32'd300040, 32'd120900, "R2 reload");
    send(1'b0, 32'd120899, "R8 top of range");
    send(1'b0, 32'd120900, "R8 just past range");
    cfg(1'b1, 32'hFFFF_FF00, 32'h200, "R2 high base");
    send(1'b0, 32'h150, "R3 modulo wrap");
    // write and request together: request sees old values
    cfg_we = 1'b1; cfg_priv = 1'b1; cfg_base = '0; cfg_limit = '0;
    send(1'b0, 32'h10, "R2 same-cycle uses old");
    cfg_we = 1'b0; m_base = '0; m_lim = '0;
    send(1'b0, 32'h10, "R2 next request uses new");
    drain();
    cfg(1'b1, 32'h4000, 32'h100, "R2 burst setup");
    bp_en = 1'b1;
    for (int i = 0; i < 12; i++)
      send(i[1:0] == 2'd3, 32'(i * 24), "R6 burst under stall");
    drain();
    bp_en = 1'b0;
    drain();
    check(sb.size() == 0, "R6 all responses seen", AW'(sb.size()), '0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule